// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. Every clock it may see a single bus cycle: a write strobe with a word address and a 16-bit data word, or a read strobe. Multi-write command sequences are followed step by step. When a sequence completes, the block emits a one-cycle command pulse together with its latched operands: a program address and data, a sector number, a chip or sector erase, an erase suspend or resume, or a burst enable or disable.

The block also holds a read-mode state that tells the device's read path what to return. The four modes are array, autoselect, unlock bypass and erase suspended. In autoselect mode the block answers reads itself with identification words. Array contents, program and erase timing, and status polling live elsewhere. A `busy` input and an `erase_active` input report those activities back to the block.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0, `burst_mode` is 0, `rd_valid` is 0 and every command pulse is low. The `mode` encoding is 0 for array, 1 for autoselect, 2 for unlock bypass and 3 for erase suspended.
- R2: A sequence begins with the unlock pair: data byte AA at word address 555, then data byte 55 at 2AA. Only address bits 10:0 and data bits 7:0 take part in these comparisons.
- R3: The program sequence is the unlock pair, then A0 at 555, then one write at any address. It raises `prog_pulse` for exactly the cycle after that fourth write. `prog_addr` and `prog_data` then hold the full address and the full 16-bit data of the fourth write.
- R4: The erase sequence is the unlock pair, 80 at 555, the unlock pair again, and then a final write. A final 10 at 555 pulses `chip_erase_pulse`. A final 30 at any address pulses `sect_erase_pulse`, and `sect_addr` takes address bits 18:12.
- R5: The unlock pair followed by 90 at 555 sets mode 1. A read strobe makes `rd_valid` high in the next cycle with `rd_data` chosen by address bits 7:0. Offset 00 gives 0x0001 and offset 01 gives 0x2281. Offset 02 gives `sect_prot` in bit 0, offset 03 gives `burst_mode` in bit 0, and every other offset gives 0. Outside mode 1 a read returns 0.
- R6: A write of byte F0 to any address changes mode 1 to mode 0 and abandons any partial sequence. In modes 2 and 3 it abandons the partial sequence but leaves the mode unchanged.
- R7: The unlock pair followed by 20 at 555 sets mode 2. In mode 2, A0 at any address followed by a write programs as in R3. In mode 2, 90 at any address followed by 00 returns to mode 0.
- R8: A write of B0 pulses `susp_pulse` and sets mode 3 only while `erase_active` is high and the mode is 0. In mode 3, a write of 30 outside a sequence pulses `resume_pulse` and sets mode 0.
- R9: The unlock pair, C0 at 555, then 01 pulses `burst_en_pulse` and sets `burst_mode`. The same prefix followed by 00 pulses `burst_dis_pulse` and clears `burst_mode`.
- R10: A write that does not match the step it arrives at abandons the partial sequence. The mode does not change and no pulse is raised. The next write is then decoded as the first step of a new sequence.
- R11: While `busy` is high, every write other than an accepted B0 leaves the mode and sequence state untouched and raises no pulse.
- R12: At most one command pulse is high in any cycle, and each lasts one cycle. Read strobes never disturb a partial write sequence.
- R13: In mode 3 the program sequence of R3 is accepted. The erase, autoselect, bypass and burst commands abandon the sequence instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write bus cycle strobe |
| rd_en | input | 1 | Read bus cycle strobe |
| addr | input | ADDR_W | Word address of the bus cycle |
| wdata | input | 16 | Write data |
| busy | input | 1 | Program or erase in progress |
| erase_active | input | 1 | A sector erase is running |
| sect_prot | input | 1 | Protection flag of the addressed sector |
| mode | output | 2 | Read mode (encoding in R1) |
| burst_mode | output | 1 | Synchronous burst configured |
| prog_pulse | output | 1 | Program command |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | 16 | Latched program data |
| chip_erase_pulse | output | 1 | Chip erase command |
| sect_erase_pulse | output | 1 | Sector erase command |
| sect_addr | output | ADDR_W-SECT_LSB | Latched sector number |
| susp_pulse | output | 1 | Erase suspend command |
| resume_pulse | output | 1 | Erase resume command |
| burst_en_pulse | output | 1 | Burst enable command |
| burst_dis_pulse | output | 1 | Burst disable command |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Autoselect read data |

## Verification
The bench uses the default parameters: a 19-bit address, an 11-bit compare field, a sector field starting at bit 12, and the default identification words. With a 19-bit address, the unlock cycles can carry set bits above bit 10, which shows that those bits are masked. The same width makes the 7-bit sector field wide enough to show that the sector number is taken from the right place. The mode paths are each driven by directed sequences. These cover autoselect reads at all four offsets, bypass entry and exit, suspend with a program inside it, burst toggling, and mismatches at several steps. The behavioural model is compared against the design in every cycle.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_ASEL   = 2'd1,
        MD_BYPASS = 2'd2,
        MD_ESUSP  = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_PROG,
        ST_BURST,
        ST_E1,
        ST_E2,
        ST_E3,
        ST_BPROG,
        ST_BRST
    } step_e;

    localparam logic [7:0] CB_UNLK1  = 8'hAA;
    localparam logic [7:0] CB_UNLK2  = 8'h55;
    localparam logic [7:0] CB_ASEL   = 8'h90;
    localparam logic [7:0] CB_PROG   = 8'hA0;
    localparam logic [7:0] CB_BYPASS = 8'h20;
    localparam logic [7:0] CB_ERASE  = 8'h80;
    localparam logic [7:0] CB_BURST  = 8'hC0;
    localparam logic [7:0] CB_CHIP   = 8'h10;
    localparam logic [7:0] CB_SECT   = 8'h30;
    localparam logic [7:0] CB_RESET  = 8'hF0;
    localparam logic [7:0] CB_SUSP   = 8'hB0;
    localparam logic [7:0] CB_ZERO   = 8'h00;
    localparam logic [7:0] CB_ONE    = 8'h01;

endpackage

// File: rtl/nor_cycle_classify.sv
module nor_cycle_classify #(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] addr_lo,
    input  logic [7:0]       data_lo,
    output logic             at_first,
    output logic             at_second,
    output logic [7:0]       cbyte
);
    localparam logic [CMP_W-1:0] FIRST_A  = CMP_W'(11'h555);
    localparam logic [CMP_W-1:0] SECOND_A = CMP_W'(11'h2AA);

    always_comb begin
        at_first  = (addr_lo == FIRST_A);
        at_second = (addr_lo == SECOND_A);
        cbyte     = data_lo;
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SECT_LSB = 12,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic              erase_active,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              at_first,
    input  logic              at_second,
    input  logic [7:0]        cbyte,
    output mode_e             mode,
    output logic              burst_mode,
    output logic              prog_pulse,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [15:0]       prog_data,
    output logic              chip_erase_pulse,
    output logic              sect_erase_pulse,
    output logic [SECT_W-1:0] sect_addr,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic              burst_en_pulse,
    output logic              burst_dis_pulse
);
    typedef struct packed {
        mode_e             mode;
        step_e             step;
        logic              burst;
        logic              prog_p;
        logic [ADDR_W-1:0] paddr;
        logic [15:0]       pdata;
        logic              chip_p;
        logic              sect_p;
        logic [SECT_W-1:0] saddr;
        logic              susp_p;
        logic              res_p;
        logic              ben_p;
        logic              bdis_p;
    } fsm_t;

    fsm_t st_d, st_q;
    logic suspend_hit;

    always_comb begin
        st_d        = st_q;
        st_d.prog_p = 1'b0;
        st_d.chip_p = 1'b0;
        st_d.sect_p = 1'b0;
        st_d.susp_p = 1'b0;
        st_d.res_p  = 1'b0;
        st_d.ben_p  = 1'b0;
        st_d.bdis_p = 1'b0;
        suspend_hit = wr_en && (cbyte == CB_SUSP) && erase_active
                      && (st_q.mode == MD_ARRAY);

        if (suspend_hit) begin
            st_d.susp_p = 1'b1;
            st_d.mode   = MD_ESUSP;
            st_d.step   = ST_IDLE;
        end else if (wr_en && !busy) begin
            if (st_q.step == ST_PROG || st_q.step == ST_BPROG) begin
                st_d.prog_p = 1'b1;
                st_d.paddr  = addr;
                st_d.pdata  = wdata;
                st_d.step   = ST_IDLE;
            end else if (cbyte == CB_RESET) begin
                st_d.step = ST_IDLE;
                if (st_q.mode == MD_ASEL) st_d.mode = MD_ARRAY;
            end else if (st_q.mode == MD_BYPASS) begin
                st_d.step = ST_IDLE;
                if (st_q.step == ST_IDLE) begin
                    if (cbyte == CB_PROG)      st_d.step = ST_BPROG;
                    else if (cbyte == CB_ASEL) st_d.step = ST_BRST;
                end else if (st_q.step == ST_BRST && cbyte == CB_ZERO) begin
                    st_d.mode = MD_ARRAY;
                end
            end else if (st_q.mode != MD_ASEL) begin
                st_d.step = ST_IDLE;
                unique case (st_q.step)
                    ST_IDLE: begin
                        if (st_q.mode == MD_ESUSP && cbyte == CB_SECT) begin
                            st_d.res_p = 1'b1;
                            st_d.mode  = MD_ARRAY;
                        end else if (at_first && cbyte == CB_UNLK1) begin
                            st_d.step = ST_U1;
                        end
                    end
                    ST_U1: if (at_second && cbyte == CB_UNLK2) st_d.step = ST_U2;
                    ST_U2: begin
                        if (at_first) begin
                            if (cbyte == CB_PROG) st_d.step = ST_PROG;
                            else if (st_q.mode == MD_ARRAY) begin
                                case (cbyte)
                                    CB_ASEL:   st_d.mode = MD_ASEL;
                                    CB_BYPASS: st_d.mode = MD_BYPASS;
                                    CB_ERASE:  st_d.step = ST_E1;
                                    CB_BURST:  st_d.step = ST_BURST;
                                    default:   st_d.step = ST_IDLE;
                                endcase
                            end
                        end
                    end
                    ST_BURST: begin
                        if (cbyte == CB_ONE) begin
                            st_d.ben_p = 1'b1;
                            st_d.burst = 1'b1;
                        end else if (cbyte == CB_ZERO) begin
                            st_d.bdis_p = 1'b1;
                            st_d.burst  = 1'b0;
                        end
                    end
                    ST_E1: if (at_first && cbyte == CB_UNLK1)  st_d.step = ST_E2;
                    ST_E2: if (at_second && cbyte == CB_UNLK2) st_d.step = ST_E3;
                    ST_E3: begin
                        if (at_first && cbyte == CB_CHIP) begin
                            st_d.chip_p = 1'b1;
                        end else if (cbyte == CB_SECT) begin
                            st_d.sect_p = 1'b1;
                            st_d.saddr  = addr[ADDR_W-1:SECT_LSB];
                        end
                    end
                    default: st_d.step = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= MD_ARRAY;
            st_q.step  <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode             = st_q.mode;
    assign burst_mode       = st_q.burst;
    assign prog_pulse       = st_q.prog_p;
    assign prog_addr        = st_q.paddr;
    assign prog_data        = st_q.pdata;
    assign chip_erase_pulse = st_q.chip_p;
    assign sect_erase_pulse = st_q.sect_p;
    assign sect_addr        = st_q.saddr;
    assign susp_pulse       = st_q.susp_p;
    assign resume_pulse     = st_q.res_p;
    assign burst_en_pulse   = st_q.ben_p;
    assign burst_dis_pulse  = st_q.bdis_p;
endmodule

// File: rtl/nor_id_read.sv
module nor_id_read
    import nor_cmd_pkg::*;
#(
    parameter logic [15:0] MFR_ID = 16'h0001,
    parameter logic [15:0] DEV_ID = 16'h2281
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [7:0]  offset,
    input  mode_e       mode,
    input  logic        sect_prot,
    input  logic        burst_mode,
    output logic        rd_valid,
    output logic [15:0] rd_data
);
    typedef struct packed {
        logic        vld;
        logic [15:0] dat;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.vld = rd_en;
        rd_d.dat = '0;
        if (rd_en && mode == MD_ASEL) begin
            case (offset)
                8'h00:   rd_d.dat = MFR_ID;
                8'h01:   rd_d.dat = DEV_ID;
                8'h02:   rd_d.dat = {15'd0, sect_prot};
                8'h03:   rd_d.dat = {15'd0, burst_mode};
                default: rd_d.dat = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.vld;
    assign rd_data  = rd_q.dat;
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter int          CMP_W    = 11,
    parameter int          SECT_LSB = 12,
    parameter logic [15:0] MFR_ID   = 16'h0001,
    parameter logic [15:0] DEV_ID   = 16'h2281,
    localparam int         SECT_W   = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              busy,
    input  logic              erase_active,
    input  logic              sect_prot,
    output logic [1:0]        mode,
    output logic              burst_mode,
    output logic              prog_pulse,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [15:0]       prog_data,
    output logic              chip_erase_pulse,
    output logic              sect_erase_pulse,
    output logic [SECT_W-1:0] sect_addr,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic              burst_en_pulse,
    output logic              burst_dis_pulse,
    output logic              rd_valid,
    output logic [15:0]       rd_data
);
    logic       at_first, at_second;
    logic [7:0] cbyte;
    mode_e      mode_w;

    nor_cycle_classify #(.CMP_W(CMP_W)) i_classify (
        .addr_lo   (addr[CMP_W-1:0]),
        .data_lo   (wdata[7:0]),
        .at_first  (at_first),
        .at_second (at_second),
        .cbyte     (cbyte)
    );

    nor_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) i_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .busy             (busy),
        .erase_active     (erase_active),
        .addr             (addr),
        .wdata            (wdata),
        .at_first         (at_first),
        .at_second        (at_second),
        .cbyte            (cbyte),
        .mode             (mode_w),
        .burst_mode       (burst_mode),
        .prog_pulse       (prog_pulse),
        .prog_addr        (prog_addr),
        .prog_data        (prog_data),
        .chip_erase_pulse (chip_erase_pulse),
        .sect_erase_pulse (sect_erase_pulse),
        .sect_addr        (sect_addr),
        .susp_pulse       (susp_pulse),
        .resume_pulse     (resume_pulse),
        .burst_en_pulse   (burst_en_pulse),
        .burst_dis_pulse  (burst_dis_pulse)
    );

    nor_id_read #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_idrd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .offset     (addr[7:0]),
        .mode       (mode_w),
        .sect_prot  (sect_prot),
        .burst_mode (burst_mode),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign mode = mode_w;
endmodule

// File: rtl/nor_cmd_checker.sv
module nor_cmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  wbyte,
    input logic        busy,
    input logic        erase_active,
    input logic [1:0]  mode,
    input logic        prog_pulse,
    input logic        chip_erase_pulse,
    input logic        sect_erase_pulse,
    input logic        susp_pulse,
    input logic        resume_pulse,
    input logic        burst_en_pulse,
    input logic        burst_dis_pulse,
    input logic        rd_valid,
    input logic [15:0] rd_data
);
    // R12
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_pulse, chip_erase_pulse, sect_erase_pulse, susp_pulse,
                  resume_pulse, burst_en_pulse, burst_dis_pulse}));

    // R3
    prog_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> $past(wr_en));

    // R8
    susp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> ($past(erase_active) && $past(mode) == 2'd0 && mode == 2'd3));

    // R8
    resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(mode) == 2'd3 && mode == 2'd0));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wbyte != 8'hB0) |=>
        (!prog_pulse && !chip_erase_pulse && !sect_erase_pulse && !resume_pulse
         && !burst_en_pulse && !burst_dis_pulse && $stable(mode)));

    // R10
    mode_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(wr_en));

    // R5
    rd_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R5
    rd_zero_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(mode) != 2'd1) |-> rd_data == 16'd0);
endmodule

bind nor_cmd_decoder nor_cmd_checker i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .rd_en            (rd_en),
    .wbyte            (wdata[7:0]),
    .busy             (busy),
    .erase_active     (erase_active),
    .mode             (mode),
    .prog_pulse       (prog_pulse),
    .chip_erase_pulse (chip_erase_pulse),
    .sect_erase_pulse (sect_erase_pulse),
    .susp_pulse       (susp_pulse),
    .resume_pulse     (resume_pulse),
    .burst_en_pulse   (burst_en_pulse),
    .burst_dis_pulse  (burst_dis_pulse),
    .rd_valid         (rd_valid),
    .rd_data          (rd_data)
);

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
    localparam int AW = 19;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic          busy = 1'b0, erase_active = 1'b0, sect_prot = 1'b0;
    logic [1:0]    mode;
    logic          burst_mode, prog_pulse, chip_erase_pulse, sect_erase_pulse;
    logic [AW-1:0] prog_addr;
    logic [15:0]   prog_data, rd_data;
    logic [SW-1:0] sect_addr;
    logic          susp_pulse, resume_pulse, burst_en_pulse, burst_dis_pulse, rd_valid;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nor_cmd_decoder i_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .busy(busy), .erase_active(erase_active), .sect_prot(sect_prot),
        .mode(mode), .burst_mode(burst_mode), .prog_pulse(prog_pulse),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_pulse(chip_erase_pulse), .sect_erase_pulse(sect_erase_pulse),
        .sect_addr(sect_addr), .susp_pulse(susp_pulse), .resume_pulse(resume_pulse),
        .burst_en_pulse(burst_en_pulse), .burst_dis_pulse(burst_dis_pulse),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // behavioural reference: mode 0..3, pending tracks what the next write means
    int          m_mode, pend;
    bit          m_burst, m_prog, m_chip, m_sect, m_susp, m_res, m_ben, m_bdis, m_rdv;
    logic [AW-1:0] m_paddr;
    logic [15:0] m_pdata, m_rdd;
    logic [SW-1:0] m_sa;
    // pend: 0 none, 1 saw AA, 2 saw pair, 3 program data, 4 burst arg,
    //       5 erase armed, 6 erase+AA, 7 erase+pair, 8 bypass data, 9 bypass exit
    always @(posedge clk) begin
        logic [7:0]  b;
        logic        a555, a2aa;
        if (!rst_n) begin
            m_mode = 0; pend = 0; m_burst = 0; m_paddr = '0; m_pdata = '0; m_sa = '0;
            {m_prog, m_chip, m_sect, m_susp, m_res, m_ben, m_bdis, m_rdv} = '0;
            m_rdd = '0;
        end else begin
            {m_prog, m_chip, m_sect, m_susp, m_res, m_ben, m_bdis} = '0;
            m_rdv = rd_en;
            m_rdd = 16'd0;
            if (rd_en && m_mode == 1) begin
                if (addr[7:0] == 8'h00)      m_rdd = 16'h0001;
                else if (addr[7:0] == 8'h01) m_rdd = 16'h2281;
                else if (addr[7:0] == 8'h02) m_rdd = {15'd0, sect_prot};
                else if (addr[7:0] == 8'h03) m_rdd = {15'd0, m_burst};
            end
            b = wdata[7:0];
            a555 = addr[10:0] == 11'h555;
            a2aa = addr[10:0] == 11'h2AA;
            if (wr_en) begin
                if (b == 8'hB0 && erase_active && m_mode == 0) begin
                    m_susp = 1; m_mode = 3; pend = 0;
                end else if (!busy) begin
                    if (pend == 3 || pend == 8) begin
                        m_prog = 1; m_paddr = addr; m_pdata = wdata; pend = 0;
                    end else if (b == 8'hF0) begin
                        pend = 0;
                        if (m_mode == 1) m_mode = 0;
                    end else if (m_mode == 2) begin
                        if (pend == 9 && b == 8'h00) m_mode = 0;
                        if (pend == 0 && b == 8'hA0)      pend = 8;
                        else if (pend == 0 && b == 8'h90) pend = 9;
                        else pend = 0;
                    end else if (m_mode == 0 || m_mode == 3) begin
                        int was;
                        was = pend;
                        pend = 0;
                        if (was == 0) begin
                            if (m_mode == 3 && b == 8'h30) begin m_res = 1; m_mode = 0; end
                            else if (a555 && b == 8'hAA) pend = 1;
                        end else if (was == 1) begin
                            if (a2aa && b == 8'h55) pend = 2;
                        end else if (was == 2 && a555) begin
                            if (b == 8'hA0) pend = 3;
                            else if (m_mode == 0) begin
                                if (b == 8'h90) m_mode = 1;
                                else if (b == 8'h20) m_mode = 2;
                                else if (b == 8'h80) pend = 5;
                                else if (b == 8'hC0) pend = 4;
                            end
                        end else if (was == 4) begin
                            if (b == 8'h01) begin m_ben = 1; m_burst = 1; end
                            else if (b == 8'h00) begin m_bdis = 1; m_burst = 0; end
                        end else if (was == 5) begin
                            if (a555 && b == 8'hAA) pend = 6;
                        end else if (was == 6) begin
                            if (a2aa && b == 8'h55) pend = 7;
                        end else if (was == 7) begin
                            if (a555 && b == 8'h10) m_chip = 1;
                            else if (b == 8'h30) begin m_sect = 1; m_sa = addr[AW-1:12]; end
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10", "mode", {30'd0, mode}, m_mode[31:0]);
            chk("R3", "prog_pulse", {31'd0, prog_pulse}, {31'd0, m_prog});
            chk("R3", "prog_addr", {13'd0, prog_addr}, {13'd0, m_paddr});
            chk("R3", "prog_data", {16'd0, prog_data}, {16'd0, m_pdata});
            chk("R4", "chip", {31'd0, chip_erase_pulse}, {31'd0, m_chip});
            chk("R4", "sect", {31'd0, sect_erase_pulse}, {31'd0, m_sect});
            chk("R4", "sect_addr", {25'd0, sect_addr}, {25'd0, m_sa});
            chk("R8", "susp", {31'd0, susp_pulse}, {31'd0, m_susp});
            chk("R8", "resume", {31'd0, resume_pulse}, {31'd0, m_res});
            chk("R9", "ben", {31'd0, burst_en_pulse}, {31'd0, m_ben});
            chk("R9", "bdis", {31'd0, burst_dis_pulse}, {31'd0, m_bdis});
            chk("R9", "burst_mode", {31'd0, burst_mode}, {31'd0, m_burst});
            chk("R5", "rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv});
            chk("R5", "rd_data", {16'd0, rd_data}, {16'd0, m_rdd});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // drive one write; returns at the negedge where its effect is visible
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; addr = '0;
    endtask

    task automatic unlock();
        wr(19'h00555, 16'h00AA);
        wr(19'h002AA, 16'h0055);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset mode", {30'd0, mode}, 32'd0);
        chk("R1", "reset pulses", {25'd0, prog_pulse, chip_erase_pulse, sect_erase_pulse,
            susp_pulse, resume_pulse, burst_en_pulse, burst_dis_pulse}, 32'd0);
        chk("R1", "reset rd/burst", {30'd0, rd_valid, burst_mode}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R3 plain program
        unlock(); wr(19'h00555, 16'h00A0); wr(19'h71234, 16'hBEEF);
        chk("R3", "program pulse", {31'd0, prog_pulse}, 32'd1);
        chk("R3", "program addr", {13'd0, prog_addr}, 32'h71234);
        chk("R3", "program data", {16'd0, prog_data}, 32'hBEEF);
        @(negedge clk);
        chk("R12", "pulse one cycle", {31'd0, prog_pulse}, 32'd0);

        // R2 high address/data bits ignored in unlock cycles
        wr(19'h7F555, 16'h12AA); wr(19'h402AA, 16'hFF55); wr(19'h55555, 16'h33A0);
        wr(19'h00042, 16'h0042);
        chk("R2", "masked unlock program", {31'd0, prog_pulse}, 32'd1);

        // R4 chip and sector erase
        unlock(); wr(19'h00555, 16'h0080); unlock(); wr(19'h00555, 16'h0010);
        chk("R4", "chip erase", {31'd0, chip_erase_pulse}, 32'd1);
        unlock(); wr(19'h00555, 16'h0080); unlock(); wr(19'h5A123, 16'h0030);
        chk("R4", "sector erase", {31'd0, sect_erase_pulse}, 32'd1);
        chk("R4", "sector number", {25'd0, sect_addr}, 32'h5A);

        // R5 autoselect reads
        unlock(); wr(19'h00555, 16'h0090);
        chk("R5", "autoselect mode", {30'd0, mode}, 32'd1);
        rd(19'h00000); chk("R5", "manufacturer", {16'd0, rd_data}, 32'h0001);
        rd(19'h10001); chk("R5", "device", {16'd0, rd_data}, 32'h2281);
        sect_prot = 1;
        rd(19'h00002); chk("R5", "protect", {16'd0, rd_data}, 32'h0001);
        sect_prot = 0;
        rd(19'h00003); rd(19'h00007);
        wr(19'h00555, 16'h00AA);
        chk("R6", "asel ignores unlock", {30'd0, mode}, 32'd1);
        wr(19'h12345, 16'h00F0);
        chk("R6", "F0 leaves autoselect", {30'd0, mode}, 32'd0);
        rd(19'h00001); chk("R5", "array read zero", {16'd0, rd_data}, 32'd0);

        // R7 unlock bypass
        unlock(); wr(19'h00555, 16'h0020);
        chk("R7", "bypass mode", {30'd0, mode}, 32'd2);
        wr(19'h33333, 16'h00A0); wr(19'h01010, 16'hCAFE);
        chk("R7", "bypass program", {31'd0, prog_pulse}, 32'd1);
        wr(19'h00000, 16'h00F0);
        chk("R6", "F0 keeps bypass", {30'd0, mode}, 32'd2);
        wr(19'h00000, 16'h0090); wr(19'h00000, 16'h0055);
        chk("R7", "bad exit stays", {30'd0, mode}, 32'd2);
        wr(19'h00000, 16'h0090); wr(19'h00000, 16'h0000);
        chk("R7", "bypass exit", {30'd0, mode}, 32'd0);

        // R9 burst configuration
        unlock(); wr(19'h00555, 16'h00C0); wr(19'h00000, 16'h0001);
        chk("R9", "burst enable", {30'd0, burst_en_pulse, burst_mode}, 32'd3);
        unlock(); wr(19'h00555, 16'h0090); rd(19'h00003);
        chk("R9", "burst status read", {16'd0, rd_data}, 32'd1);
        wr(19'h00000, 16'h00F0);
        unlock(); wr(19'h00555, 16'h00C0); wr(19'h00000, 16'h0000);
        chk("R9", "burst disable", {30'd0, burst_dis_pulse, burst_mode}, 32'd2);

        // R10 mismatches
        wr(19'h00555, 16'h00AA); wr(19'h002AA, 16'h0056);
        wr(19'h00555, 16'h00A0); wr(19'h00100, 16'h1111);
        chk("R10", "abort no program", {31'd0, prog_pulse}, 32'd0);
        unlock(); wr(19'h00555, 16'h0077); wr(19'h00555, 16'h0090);
        chk("R10", "abort mode kept", {30'd0, mode}, 32'd0);
        wr(19'h00555, 16'h00B0);
        chk("R8", "B0 without erase", {31'd0, susp_pulse}, 32'd0);

        // R12 read inside a partial sequence
        unlock(); rd(19'h00000); wr(19'h00555, 16'h00A0); wr(19'h00200, 16'h2222);
        chk("R12", "read does not break sequence", {31'd0, prog_pulse}, 32'd1);

        // R11 busy, R8 suspend/resume, R13 program while suspended
        erase_active = 1; busy = 1;
        unlock(); wr(19'h00555, 16'h00A0);
        busy = 0;
        wr(19'h00300, 16'h3333);
        chk("R11", "busy writes ignored", {31'd0, prog_pulse}, 32'd0);
        busy = 1;
        wr(19'h00000, 16'h00B0);
        chk("R8", "suspend", {31'd0, susp_pulse}, 32'd1);
        chk("R8", "suspend mode", {30'd0, mode}, 32'd3);
        busy = 0;
        unlock(); wr(19'h00555, 16'h00A0); wr(19'h00400, 16'h4444);
        chk("R13", "program in suspend", {31'd0, prog_pulse}, 32'd1);
        unlock(); wr(19'h00555, 16'h0090);
        chk("R13", "no autoselect in suspend", {30'd0, mode}, 32'd3);
        wr(19'h00000, 16'h00B0);
        chk("R8", "no second suspend", {31'd0, susp_pulse}, 32'd0);
        wr(19'h00000, 16'h0030);
        chk("R8", "resume", {31'd0, resume_pulse}, 32'd1);
        chk("R8", "resume mode", {30'd0, mode}, 32'd0);
        erase_active = 0;

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule